// File: doc/BRIEF.md
# Multi-Format Synchronous Serial Master

This block is the shift engine of a synchronous serial master. It takes one data word at a time from a valid/ready input and sends it over a four-wire link: serial clock, master-out data, master-in data and one active-low slave select. Every bit sampled from the master-in line is collected, and each complete received word is returned on a one-cycle valid output. Bits go out most significant first. Received words are right-justified in a 32-bit output.

Three framing styles share one bit-timing engine. The first is clock-polarity/phase SPI, which uses slave select as the frame delimiter. The second is a pulse-framed format: a one-bit-period frame pulse comes just before the first data bit, and slave select stays idle. The third is a half-duplex format: an 8-bit control word goes out first, then a response frame is read in while the output line is held low.

The format, frame length, clock divider and receive sample delay are all inputs. They are captured when a word is accepted, so they can change between transfers.

Top module: `sync_serial_master`

## Requirements
- R1: `cfg_fmt` selects the frame format. 0 is SPI, 1 is pulse-framed, 2 is control-word/response, and 3 behaves exactly like 0. The format is captured when a word is accepted.
- R2: The frame length is `cfg_len`+1 bits, and values of `cfg_len` below 3 give 4 bits. Data is sent MSB first from the low bits of `tx_data`. The received word is right-justified in `rx_data`, and its upper bits are zero.
- R3: While `rst` is high and after it is released, all of the following hold: `sclk` is 0, `ss_n` is 1, and `mosi`, `sfrm`, `busy` and `rx_valid` are 0. If the divider is enabled, `tx_ready` is 1.
- R4: In SPI format, `sclk` idles at `cfg_cpol`. With `cfg_cpha`=0, data is captured on the first (leading) edge of each bit. With `cfg_cpha`=1, it is captured on the second (trailing) edge. A frame of N bits produces exactly 2N clock edges.
- R5: Each half period of `sclk` lasts `cfg_div`/2 clock cycles, with odd values rounded down. A value below 2 holds `tx_ready` low and starts no transfer.
- R6: Master-in data is sampled `cfg_rx_dly` clock cycles after the capturing `sclk` edge. A delay of 0 samples at that edge. The delay must not exceed `cfg_div`/2.
- R7: `busy` rises on the clock edge that accepts a word and falls on the edge that ends the last bit. It therefore stays high for N·`cfg_div` cycles, where N counts every bit the frame clocks. In SPI and control formats, `ss_n` is low for exactly those same cycles, and it is high again when `busy` falls.
- R8: In the pulse-framed format, the clock uses polarity 0 and phase 1. `sfrm` is high for one bit period (`cfg_div` cycles) just before the first data bit. `ss_n` stays high, and `mosi` is 0 during the pulse.
- R9: In the control format, the clock uses polarity 0 and phase 0. `tx_data[7:0]` is sent MSB first, then `mosi` is held at 0 while the programmed number of response bits is received. Only the response bits are received.
- R10: After the last received bit is sampled, `rx_valid` is high for one cycle together with the word. There is exactly one such pulse per frame.
- R11: `tx_ready` is high only while the engine is idle. A word is accepted on a clock edge where `tx_valid` and `tx_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_fmt | input | 2 | Frame format select |
| cfg_cpol | input | 1 | SPI clock idle level |
| cfg_cpha | input | 1 | SPI capture edge select |
| cfg_len | input | 5 | Frame length minus one |
| cfg_div | input | 16 | Serial clock divider (even, at least 2) |
| cfg_rx_dly | input | 3 | Receive sample delay in clock cycles |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | 32 | Transmit word, right-justified |
| tx_ready | output | 1 | Engine can accept a word |
| rx_valid | output | 1 | Received word strobe |
| rx_data | output | 32 | Received word, right-justified |
| busy | output | 1 | Transfer in progress |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | 1 | Active-low slave select |
| sfrm | output | 1 | Frame pulse for the pulse-framed format |

## Verification
The assertions assume three things. The `cfg_div` value seen by the checker is the one held at each accept. `cfg_rx_dly` never exceeds half the divider, so a delayed sample always lands before the frame ends. Frames are long enough that two `rx_valid` pulses can never be adjacent. The stimulus changes configuration only while the engine is idle, and it pairs every delay with a divider of at least twice that delay. It also models a slave whose response lags by a chosen number of cycles, so that the delay setting is the only thing that separates a correct capture from a shifted one.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic [1:0] {
    FMT_SPI     = 2'd0,
    FMT_PULSE   = 2'd1,
    FMT_CTRL    = 2'd2,
    FMT_SPI_ALT = 2'd3
  } fmt_e;

  localparam int CTRL_BITS = 8;
  localparam int MIN_BITS  = 4;
endpackage

// File: rtl/ssm_halfclk.sv
// Half-period timer: one tick per half serial-clock period while running.
module ssm_halfclk #(
  parameter int HW = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [HW-1:0] half,
  output logic          tick
);
  logic [HW-1:0] cnt;

  assign tick = run && (cnt == half - HW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (tick)   cnt <= '0;
    else             cnt <= cnt + HW'(1);
  end
endmodule

// File: rtl/ssm_rx_delay.sv
// Delays the sample strobe by a selectable number of clock cycles.
module ssm_rx_delay #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ev_in,
  input  logic [DLY_W-1:0] sel,
  output logic             ev_out
);
  localparam int TAPS = (1 << DLY_W) - 1;

  logic [TAPS-1:0] dl;

  for (genvar i = 0; i < TAPS; i++) begin : g_tap
    if (i == 0) begin : g_first
      always_ff @(posedge clk) dl[0] <= rst ? 1'b0 : ev_in;
    end else begin : g_next
      always_ff @(posedge clk) dl[i] <= rst ? 1'b0 : dl[i-1];
    end
  end

  assign ev_out = (sel == '0) ? ev_in : dl[sel - DLY_W'(1)];
endmodule

// File: rtl/ssm_rx_shift.sv
// Collects sampled bits and emits a right-justified word after the last one.
module ssm_rx_shift #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp,
  input  logic              din,
  input  logic [CNT_W-1:0]  nbits,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data
);
  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr       <= '0;
      cnt      <= '0;
      rx_valid <= 1'b0;
      rx_data  <= '0;
    end else begin
      rx_valid <= 1'b0;
      if (smp) begin
        if (cnt == nbits - CNT_W'(1)) begin
          rx_data  <= {sr[WORD_W-2:0], din};
          rx_valid <= 1'b1;
          sr       <= '0;
          cnt      <= '0;
        end else begin
          sr  <= {sr[WORD_W-2:0], din};
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import ssm_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int DIV_W  = 16,
  parameter int DLY_W  = 3,
  localparam int LEN_W = $clog2(WORD_W),
  localparam int CNT_W = LEN_W + 2,
  localparam int HW    = DIV_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_fmt,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [LEN_W-1:0]  cfg_len,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [DLY_W-1:0]  cfg_rx_dly,
  input  logic              tx_valid,
  input  logic [WORD_W-1:0] tx_data,
  output logic              tx_ready,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_data,
  output logic              busy,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              ss_n,
  output logic              sfrm
);
  // Frame state, captured at accept
  logic             active, phase_b;
  logic [CNT_W-1:0] bit_left, len_l;
  fmt_e             fmt_l;
  logic             cpol_l;
  logic [HW-1:0]    half_l;
  logic [DLY_W-1:0] dly_l;
  logic [WORD_W:0]  tx_sr;

  // Next-frame decode
  fmt_e              fmt_n;
  logic              cpol_n, cpha_n, accept, tick, in_pre, smp_ev, smp_dly, idle_lvl;
  logic [CNT_W-1:0]  len_n, pre_n;
  logic [WORD_W-1:0] aligned;
  logic [WORD_W:0]   load_n;

  assign tx_ready = !active && (cfg_div[DIV_W-1:1] != '0);
  assign accept   = tx_valid && tx_ready;
  assign busy     = active;
  assign mosi     = tx_sr[WORD_W];

  always_comb begin
    fmt_n = (fmt_e'(cfg_fmt) == FMT_SPI_ALT) ? FMT_SPI : fmt_e'(cfg_fmt);
    len_n = (cfg_len < LEN_W'(MIN_BITS - 1)) ? CNT_W'(MIN_BITS)
                                              : CNT_W'(cfg_len) + CNT_W'(1);
    aligned = tx_data << (CNT_W'(WORD_W) - len_n);
    case (fmt_n)
      FMT_PULSE: begin
        pre_n = CNT_W'(1);  cpol_n = 1'b0; cpha_n = 1'b1;
        load_n = {1'b0, aligned};
      end
      FMT_CTRL: begin
        pre_n = CNT_W'(CTRL_BITS); cpol_n = 1'b0; cpha_n = 1'b0;
        load_n = {tx_data[CTRL_BITS-1:0], (WORD_W+1-CTRL_BITS)'(0)};
      end
      default: begin
        pre_n = '0; cpol_n = cfg_cpol; cpha_n = cfg_cpha;
        load_n = {aligned, 1'b0};
      end
    endcase
    idle_lvl = (fmt_n == FMT_SPI) ? cfg_cpol : 1'b0;
  end

  ssm_halfclk #(.HW(HW)) u_half (
    .clk(clk), .rst(rst), .run(active), .half(half_l), .tick(tick)
  );

  // Capture point is the end of the first half of every received bit.
  assign in_pre = bit_left > len_l;
  assign smp_ev = active && tick && !phase_b && !in_pre;

  ssm_rx_delay #(.DLY_W(DLY_W)) u_dly (
    .clk(clk), .rst(rst), .ev_in(smp_ev), .sel(dly_l), .ev_out(smp_dly)
  );

  ssm_rx_shift #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_rx (
    .clk(clk), .rst(rst), .smp(smp_dly), .din(miso), .nbits(len_l),
    .rx_valid(rx_valid), .rx_data(rx_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      phase_b  <= 1'b0;
      bit_left <= '0;
      len_l    <= CNT_W'(MIN_BITS);
      fmt_l    <= FMT_SPI;
      cpol_l   <= 1'b0;
      half_l   <= '0;
      dly_l    <= '0;
      tx_sr    <= '0;
      sclk     <= 1'b0;
      ss_n     <= 1'b1;
      sfrm     <= 1'b0;
    end else if (!active) begin
      sclk <= idle_lvl;
      if (accept) begin
        active   <= 1'b1;
        phase_b  <= 1'b0;
        bit_left <= pre_n + len_n;
        len_l    <= len_n;
        fmt_l    <= fmt_n;
        cpol_l   <= cpol_n;
        half_l   <= cfg_div[DIV_W-1:1];
        dly_l    <= cfg_rx_dly;
        tx_sr    <= load_n;
        sclk     <= cpol_n ^ cpha_n;
        ss_n     <= (fmt_n == FMT_PULSE);
        sfrm     <= (fmt_n == FMT_PULSE);
      end
    end else if (tick) begin
      if (!phase_b) begin
        phase_b <= 1'b1;
        sclk    <= ~sclk;
      end else if (bit_left == CNT_W'(1)) begin
        active   <= 1'b0;
        phase_b  <= 1'b0;
        bit_left <= '0;
        tx_sr    <= '0;
        sclk     <= cpol_l;
        ss_n     <= 1'b1;
        sfrm     <= 1'b0;
      end else begin
        phase_b  <= 1'b0;
        bit_left <= bit_left - CNT_W'(1);
        tx_sr    <= {tx_sr[WORD_W-1:0], 1'b0};
        sclk     <= ~sclk;
        sfrm     <= 1'b0;
      end
    end
  end

  // fmt_l is kept for visibility of the captured format in debug views.
  logic fmt_unused;
  assign fmt_unused = ^fmt_l;
endmodule

// File: rtl/ssm_checker.sv
module ssm_checker #(
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_valid,
  input logic             tx_ready,
  input logic             busy,
  input logic             ss_n,
  input logic             sfrm,
  input logic             rx_valid,
  input logic [DIV_W-1:0] cfg_div
);
  assert_ss_inside_busy_R7: assert property (@(posedge clk) disable iff (rst)
    !ss_n |-> busy);

  assert_release_at_end_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> ss_n);

  assert_frame_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    sfrm |-> (busy && ss_n));

  assert_accept_starts_R11: assert property (@(posedge clk) disable iff (rst)
    (tx_valid && tx_ready) |=> busy);

  assert_ready_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    busy |-> !tx_ready);

  assert_divider_gate_R5: assert property (@(posedge clk) disable iff (rst)
    (cfg_div < DIV_W'(2)) |-> !tx_ready);

  assert_single_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    rx_valid |=> !rx_valid);
endmodule

bind sync_serial_master ssm_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .busy(busy), .ss_n(ss_n), .sfrm(sfrm), .rx_valid(rx_valid),
  .cfg_div(cfg_div)
);

// File: tb/sync_serial_master_bench.sv
`timescale 1ns/1ps
module sync_serial_master_bench;
  typedef struct packed {
    logic [1:0]  fmt;
    logic        cpol;
    logic        cpha;
    logic [4:0]  len;
    logic [7:0]  div;
    logic [2:0]  dly;
    logic [2:0]  lag;
    logic [31:0] tx;
    logic [31:0] sw;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{2'd0, 1'b0, 1'b0, 5'd7,  8'd4,  3'd0, 3'd0, 32'h0000_00A5, 32'h0000_003C},
    '{2'd0, 1'b0, 1'b1, 5'd15, 8'd2,  3'd0, 3'd0, 32'h0000_1234, 32'h0000_BEEF},
    '{2'd0, 1'b1, 1'b0, 5'd31, 8'd6,  3'd0, 3'd0, 32'hDEAD_BEEF, 32'h0F1E_2D3C},
    '{2'd0, 1'b1, 1'b1, 5'd3,  8'd8,  3'd0, 3'd0, 32'h0000_0009, 32'h0000_0006},
    '{2'd1, 1'b0, 1'b0, 5'd11, 8'd4,  3'd0, 3'd0, 32'h0000_0ABC, 32'h0000_05A3},
    '{2'd2, 1'b0, 1'b0, 5'd15, 8'd4,  3'd0, 3'd0, 32'h0000_00C3, 32'h0000_8181},
    '{2'd0, 1'b0, 1'b0, 5'd23, 8'd4,  3'd2, 3'd3, 32'h0012_3456, 32'h0087_6543},
    '{2'd2, 1'b0, 1'b0, 5'd4,  8'd2,  3'd0, 3'd0, 32'h0000_005E, 32'h0000_0013},
    '{2'd3, 1'b0, 1'b0, 5'd9,  8'd10, 3'd5, 3'd0, 32'h0000_03FF, 32'h0000_02AA}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_fmt = 2'd0;
  logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0;
  logic [4:0]  cfg_len = 5'd7;
  logic [15:0] cfg_div = 16'd4;
  logic [2:0]  cfg_rx_dly = 3'd0;
  logic        tx_valid = 1'b0;
  logic [31:0] tx_data = '0;
  logic        tx_ready, rx_valid, busy, sclk, mosi, miso, ss_n, sfrm;
  logic [31:0] rx_data;

  always #2.5 clk = ~clk;

  sync_serial_master u_sync_serial_master (
    .clk(clk), .rst(rst), .cfg_fmt(cfg_fmt), .cfg_cpol(cfg_cpol),
    .cfg_cpha(cfg_cpha), .cfg_len(cfg_len), .cfg_div(cfg_div),
    .cfg_rx_dly(cfg_rx_dly), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .rx_valid(rx_valid), .rx_data(rx_data),
    .busy(busy), .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n),
    .sfrm(sfrm)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Slave model: presents bits from s_out, captures mosi into s_in
  logic [39:0] s_out = '0, s_in = '0;
  int          s_idx = 0, lag = 0;
  logic        s_armed = 1'b0, s_started = 1'b0, e_cpol = 1'b0, e_cpha = 1'b0;
  logic        slave_bit;
  logic [7:0]  hist = '0;

  assign slave_bit = (s_idx < 40) ? s_out[39 - s_idx] : 1'b0;
  assign miso = (lag == 0) ? slave_bit : hist[lag-1];

  always @(posedge clk) hist <= {hist[6:0], slave_bit};

  always @(sclk) begin
    if (s_armed) begin
      if (sclk != e_cpol) begin
        if (!e_cpha) s_in = {s_in[38:0], mosi};
        else begin
          if (s_started) s_idx = s_idx + 1;
          s_started = 1'b1;
        end
      end else begin
        if (!e_cpha) s_idx = s_idx + 1;
        else s_in = {s_in[38:0], mosi};
      end
    end
  end

  // Monitors, sampled away from the active edge
  logic mon_on = 1'b0, prev_sclk = 1'b0;
  int   busy_cyc, ss_cyc, frm_cyc, tog, rx_cnt;
  logic [31:0] rx_got;

  always @(negedge clk) begin
    if (mon_on) begin
      busy_cyc += int'(busy);
      ss_cyc   += int'(!ss_n);
      frm_cyc  += int'(sfrm);
      if (sclk != prev_sclk) tog++;
      prev_sclk = sclk;
      if (rx_valid) begin
        rx_cnt++;
        rx_got = rx_data;
      end
    end
  end

  task automatic start_xfer(input vec_t v, input int lenb, input int pre);
    logic [63:0] mask;
    mask = (64'd1 << lenb) - 64'd1;
    cfg_fmt = v.fmt; cfg_cpol = v.cpol; cfg_cpha = v.cpha; cfg_len = v.len;
    cfg_div = {8'd0, v.div}; cfg_rx_dly = v.dly; lag = int'(v.lag);
    e_cpol = (v.fmt == 2'd1 || v.fmt == 2'd2) ? 1'b0 : v.cpol;
    e_cpha = (v.fmt == 2'd1) ? 1'b1 : (v.fmt == 2'd2) ? 1'b0 : v.cpha;
    repeat (3) @(negedge clk);
    s_out = ({8'd0, v.sw} & mask[39:0]) << (40 - pre - lenb);
    s_in = '0; s_idx = 0; s_started = 1'b0; s_armed = 1'b1;
    busy_cyc = 0; ss_cyc = 0; frm_cyc = 0; tog = 0; rx_cnt = 0; rx_got = '0;
    prev_sclk = sclk; mon_on = 1'b1;
    tx_data = v.tx; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic finish_xfer();
    int guard = 0;
    while (busy && guard < 4000) begin
      @(negedge clk);
      guard++;
    end
    repeat (3) @(negedge clk);
    mon_on = 1'b0;
    s_armed = 1'b0;
  endtask

  task automatic run_vec(input vec_t v, input string tag);
    int lenb, pre, nb;
    logic [63:0] mask;
    lenb = (v.len < 5'd3) ? 4 : int'(v.len) + 1;
    pre  = (v.fmt == 2'd1) ? 1 : (v.fmt == 2'd2) ? 8 : 0;
    nb   = lenb + pre;
    mask = (64'd1 << lenb) - 64'd1;
    start_xfer(v, lenb, pre);
    finish_xfer();
    chk({tag, " R10 rx word"}, {32'd0, rx_got}, {32'd0, v.sw} & mask);
    chk({tag, " R10 rx strobes"}, 64'(rx_cnt), 64'd1);
    chk({tag, " R7 busy cycles"}, 64'(busy_cyc), 64'(nb * int'(v.div)));
    chk({tag, " R4 sclk edges"}, 64'(tog), 64'(2 * nb));
    chk({tag, " R4 sclk idle"}, {63'd0, sclk}, {63'd0, e_cpol});
    if (v.fmt == 2'd2) begin
      chk({tag, " R9 control word"}, 64'((s_in >> lenb) & 40'hFF), {56'd0, v.tx[7:0]});
      chk({tag, " R9 mosi idle in response"}, {24'd0, s_in} & mask, 64'd0);
    end else begin
      chk({tag, " R2 mosi word"}, {24'd0, s_in} & mask, {32'd0, v.tx} & mask);
    end
    if (v.fmt == 2'd1) begin
      chk({tag, " R8 ss idle"}, 64'(ss_cyc), 64'd0);
      chk({tag, " R8 pulse width"}, 64'(frm_cyc), 64'(v.div));
      chk({tag, " R8 pulse bit zero"}, {63'd0, s_in[lenb]}, 64'd0);
    end else begin
      chk({tag, " R7 ss cycles"}, 64'(ss_cyc), 64'(busy_cyc));
      chk({tag, " R8 no pulse"}, 64'(frm_cyc), 64'd0);
    end
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual expired expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    vec_t d;
    repeat (3) @(negedge clk);
    chk("R3 sclk in reset", {63'd0, sclk}, 64'd0);
    chk("R3 ss_n in reset", {63'd0, ss_n}, 64'd1);
    rst = 1'b0;
    @(negedge clk);
    chk("R3 sclk", {63'd0, sclk}, 64'd0);
    chk("R3 ss_n", {63'd0, ss_n}, 64'd1);
    chk("R3 mosi/sfrm/busy/rx_valid", {60'd0, mosi, sfrm, busy, rx_valid}, 64'd0);
    chk("R3 tx_ready", {63'd0, tx_ready}, 64'd1);

    // Table of vectors: R1 formats, R2 lengths, R4 modes, R5 dividers, R6 delay
    for (int i = 0; i < NV; i++) begin
      run_vec(VECS[i], $sformatf("R1 vec%0d", i));
    end

    // R2: length below minimum gives 4 bits
    d = '{2'd0, 1'b0, 1'b0, 5'd1, 8'd4, 3'd0, 3'd0, 32'h0000_000B, 32'h0000_0005};
    run_vec(d, "R2 clamp");

    // R6: lagging slave without delay captures a shifted word
    d = '{2'd0, 1'b0, 1'b0, 5'd7, 8'd4, 3'd0, 3'd3, 32'h0000_0011, 32'h0000_00A5};
    start_xfer(d, 8, 0);
    finish_xfer();
    n_chk++;
    if (rx_got == 32'h0000_00A5) begin
      n_fail++;
      $display("FAIL R6 no-delay capture: actual %0h expected a shifted word", rx_got);
    end

    // R5: divider below 2 blocks transfers
    cfg_div = 16'd0; tx_valid = 1'b1;
    repeat (10) @(negedge clk);
    chk("R5 div0 ready", {63'd0, tx_ready}, 64'd0);
    chk("R5 div0 busy/ss", {62'd0, busy, ss_n}, 64'd1);
    cfg_div = 16'd1;
    repeat (10) @(negedge clk);
    chk("R5 div1 ready", {63'd0, tx_ready}, 64'd0);
    chk("R5 div1 busy", {63'd0, busy}, 64'd0);
    tx_valid = 1'b0;
    cfg_div = 16'd4;
    @(negedge clk);
    chk("R11 ready restored", {63'd0, tx_ready}, 64'd1);

    // R3: reset during a transfer returns to the idle state
    start_xfer(VECS[0], 8, 0);
    repeat (5) @(negedge clk);
    chk("R11 ready low while busy", {62'd0, tx_ready, busy}, 64'd1);
    rst = 1'b1;
    @(negedge clk);
    chk("R3 abort busy", {63'd0, busy}, 64'd0);
    chk("R3 abort ss_n/sclk", {62'd0, ss_n, sclk}, 64'd2);
    rst = 1'b0;
    mon_on = 1'b0; s_armed = 1'b0;
    @(negedge clk);
    run_vec(VECS[1], "R1 after abort");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule